// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block derives the 16x oversampling strobe of a UART from a fast reference clock. The divisor has a 16-bit integer part D and a 4-bit fraction F in sixteenths, so the ideal setting is the reference frequency divided by sixteen times the baud rate. For example, a 125 MHz reference at 115200 baud uses D = 0x0043 and F = 0xD. The fraction is applied by stretching chosen strobe periods by one reference cycle. A phase accumulator picks the stretched periods so that they are spread evenly and the long-run average period is exactly D + F/16.

Software loads the divisor through a byte-wide write port. The block outputs a one-cycle sample strobe and a one-cycle bit strobe, which marks every sixteenth sample strobe. A new divisor is picked up only when the running period reloads, so a period already in progress is never cut short or stretched.

Top module: `frac_baud_gen`

## Requirements
- R1: A synchronous active-high `rst` clears the divisor, fraction, period counter, phase accumulator and strobe counter, and both strobes stay low while the divisor is zero.
- R2: When `wr_en` is high at a clock edge, `wr_sel` chooses the target. `wr_sel`=0 writes `wr_data` into integer bits [15:8]. `wr_sel`=1 writes integer bits [7:0]. `wr_sel`=2 writes the fraction from `wr_data[3:0]`.
- R3: On a fraction write, `wr_data[7:4]` has no effect on strobe timing. A write with `wr_sel`=3 changes nothing.
- R4: With an integer divisor of zero, no strobe is produced once the running period has expired.
- R5: With F=0, `tick16` is high for one cycle in every D cycles.
- R6: Within any run of 16 consecutive strobe intervals, exactly F intervals last D+1 cycles and the others last D cycles.
- R7: After reset, the interval following the k-th strobe (k from 1) is D + floor(k·F/16) − floor((k−1)·F/16) cycles.
- R8: `tick_bit` is high together with the 16th, 32nd, ... `tick16` since reset, and is never high at any other time.
- R9: A divisor change made during a period does not alter that period. It applies from the next reload onwards. When the divisor was zero and idle, the first strobe occurs in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 integer high, 1 integer low, 2 fraction |
| wr_data | input | 8 | Write data |
| tick16 | output | 1 | One-cycle 16x sample strobe |
| tick_bit | output | 1 | One-cycle bit-rate strobe |

## Verification
A sample strobe is due in the cycle after the write edge that makes an idle divisor nonzero. After that, the next strobe is due D or D+1 cycles after the previous one, and the bit strobe is due in the same cycle as its sample strobe. The driver pushes the expected interval and the expected bit-strobe value for each strobe into a queue. The monitor samples on the falling clock edge, measures each interval from the previous strobe, and compares both values. Any strobe that arrives while the queue is empty counts as a failure, and this is how the zero-divisor stop is checked.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4,
  parameter int OVS_W  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic       tick16,
  output logic       tick_bit
);
  localparam int HI_W = INT_W - 8;

  logic [INT_W-1:0]  div_q;
  logic [FRAC_W-1:0] frac_q;
  logic [INT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [OVS_W-1:0]  sub;
  logic [FRAC_W:0]   acc_sum;

  assign acc_sum  = {1'b0, acc} + {1'b0, frac_q};
  assign tick16   = (cnt == '0) && (div_q != '0);
  assign tick_bit = tick16 && (sub == {OVS_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      frac_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0:    div_q[INT_W-1:8] <= wr_data[HI_W-1:0];
        2'd1:    div_q[7:0]       <= wr_data;
        2'd2:    frac_q           <= wr_data[FRAC_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      acc <= '0;
      sub <= '0;
    end else if (tick16) begin
      acc <= acc_sum[FRAC_W-1:0];
      sub <= sub + 1'b1;
      cnt <= div_q - 1'b1 + {{(INT_W-1){1'b0}}, acc_sum[FRAC_W]};
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (cnt == '0 && div_q == '0 && acc == '0 && sub == '0));

  p_frac_low_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2) |=> frac_q == $past(wr_data[FRAC_W-1:0]));

  p_sel3_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3) |=> ($stable(div_q) && $stable(frac_q)));

  p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    tick16 |=> (cnt == $past(div_q) - 1'b1 || cnt == $past(div_q)));

  p_phase_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !tick16 |=> $stable(acc));

  p_sub_step_r8: assert property (@(posedge clk) disable iff (rst)
    tick16 |=> sub == $past(sub) + 1'b1);

  p_mid_period_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !tick16) |=> !tick16 || $past(cnt) == 1);
endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
  localparam int CLK_NS = 8;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic tick16, tick_bit;

  int checks = 0, errors = 0;
  int cyc = 0, last = 0, ntick = 0;
  int qp[$];
  bit qb[$];

  frac_baud_gen u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
                    .wr_data(wr_data), .tick16(tick16), .tick_bit(tick_bit));

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops one expected item per sample strobe
  always @(negedge clk) begin
    if (!rst && tick16) begin
      ntick = ntick + 1;
      checks++;
      if (qp.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected strobe at cycle %0d: actual 1 expected 0", cyc);
      end else begin
        int p; bit b;
        p = qp.pop_front();
        b = qb.pop_front();
        if (p >= 0 && (cyc - last) != p) begin
          errors++;
          $display("FAIL R5 R6 R7 R9 interval before strobe %0d: actual %0d expected %0d",
                   ntick, cyc - last, p);
        end
        checks++;
        if (tick_bit !== b) begin
          errors++;
          $display("FAIL R8 bit strobe at strobe %0d: actual %0b expected %0b", ntick, tick_bit, b);
        end
      end
      last = cyc;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    ntick = 0;
  endtask

  function automatic int ext(input int k, input int f);
    return (k * f) / 16 - ((k - 1) * f) / 16;
  endfunction

  // first interval uses d0, the rest use d
  task automatic push_run(input int d0, input int d, input int f, input int n);
    qp.push_back(-1); qb.push_back(0);
    for (int k = 1; k < n; k++) begin
      qp.push_back((k == 1 ? d0 : d) + ext(k, f));
      qb.push_back(((k + 1) % 16) == 0);
    end
  endtask

  task automatic drain();
    while (qp.size() != 0) @(negedge clk);
  endtask

  initial begin
    // R1 reset state, R4 zero divisor idle
    do_reset();
    check("R1 tick16 after reset", int'(tick16), 0);
    check("R1 tick_bit after reset", int'(tick_bit), 0);
    repeat (50) @(negedge clk);
    check("R4 no strobes with zero divisor", ntick, 0);

    // R5 R8 integer-only divisor
    push_run(5, 5, 0, 34);
    wr(2'd1, 8'd5);
    drain();
    check("R5 strobe count", ntick, 34);

    // R3 upper nibble and select 3 ignored, R2 low byte
    do_reset();
    push_run(3, 3, 5, 40);
    wr(2'd2, 8'hF5);
    wr(2'd3, 8'h77);
    wr(2'd1, 8'd3);
    drain();
    check("R3 strobe count", ntick, 40);

    // R6 R7 115200 baud setting at 125 MHz
    do_reset();
    push_run(67, 67, 13, 48);
    wr(2'd2, 8'h0D);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h43);
    drain();
    check("R6 strobe count", ntick, 48);

    // R2 high byte, R9 partial divisor used for first period, 9600 baud
    do_reset();
    push_run(8'h2D, 16'h032D, 13, 20);
    wr(2'd2, 8'h0D);
    wr(2'd1, 8'h2D);
    wr(2'd0, 8'h03);
    drain();
    check("R2 strobe count", ntick, 20);

    // R9 change in mid period, then R4 stop
    do_reset();
    qp.push_back(-1); qb.push_back(0);
    qp.push_back(20); qb.push_back(0);
    qp.push_back(20); qb.push_back(0);
    qp.push_back(8);  qb.push_back(0);
    qp.push_back(8);  qb.push_back(0);
    wr(2'd1, 8'd20);
    while (ntick < 2) @(negedge clk);
    repeat (5) @(negedge clk);
    wr(2'd1, 8'd8);
    while (ntick < 5) @(negedge clk);
    repeat (2) @(negedge clk);
    wr(2'd1, 8'd0);
    repeat (60) @(negedge clk);
    check("R9 strobes before stop", ntick, 5);
    check("R4 strobes after zero write", ntick, 5);
    check("R9 queue consumed", qp.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule